// File: doc/BRIEF.md
# Row-Based Data-Parallel Lane Mover

This block moves operands between the lanes of a 64-lane wavefront in a single registered step. The wavefront is organised as four rows of sixteen lanes, and each row is split into four banks of four lanes. For every destination lane, a control code picks one source lane. The data of that source lane becomes the lane's new value. The available moves are:

- a permute inside each group of four lanes;
- a mirror of each row, and a mirror of each half-row;
- shifts and a rotate confined to a row;
- single-lane shifts and rotates across the whole wavefront;
- two broadcasts that copy one lane into following rows.

Several inputs decide what each lane finally receives: a row enable mask, a bank enable mask, a per-lane exec mask and a bound-zero bit. A lane can keep the old destination value supplied beside the data. When its source is unusable, it can instead receive zero. The result is registered and appears one clock after `in_valid`, together with `out_valid_o`.

Top module: `lm_lane_mover`

## Requirements
- R1: While `rst_n` is low and after its release, before any accepted operation, `lane_data_o` is all zeros and `out_valid_o` is 0.
- R2: An operation presented with `in_valid`=1 appears on `lane_data_o` one clock later, and `out_valid_o` equals `in_valid` delayed by one clock. When `in_valid`=0, `lane_data_o` keeps its value.
- R3: Opcode 0 (quad permute) works on aligned groups of four lanes. Lane j of each group (j=0..3) takes group lane `arg_i[2j+1:2j]`.
- R4: Opcode 1 gives row lane k the value of row lane 15-k. Opcode 2 mirrors each eight-lane half-row: lane k takes lane 7-k in the lower half and lane 23-k in the upper half.
- R5: Let n be `arg_i[3:0]`. Opcode 3 gives row lane k the value of row lane k+n. Opcode 4 gives it row lane k-n. A source beyond the row edge is invalid. With n=0, each lane reads itself.
- R6: Opcode 5 gives row lane k the value of row lane (k-n) mod 16.
- R7: The wave-wide moves use a step of one lane. Opcode 6 reads lane i+1, and lane 63 has an invalid source. Opcode 7 reads lane i-1, and lane 0 has an invalid source. Opcode 8 reads lane (i+1) mod 64. Opcode 9 reads lane (i+63) mod 64.
- R8: Opcode 10 fills rows 1..3 from the last lane of the row before, and row 0 keeps its old value. Opcode 11 fills rows 2 and 3 from lane 31, and rows 0 and 1 keep their old values.
- R9: A lane whose row bit in `row_en_i` is 0, or whose bank bit in `bank_en_i` is 0, takes its old value, whatever the state of its source. Bank b holds row lanes 4b..4b+3.
- R10: A source lane is invalid if it lies out of range or if its `exec_i` bit is 0. A write-enabled lane with an invalid source gets zero when `bound_zero_i`=1.
- R11: A write-enabled lane with an invalid source takes its old value when `bound_zero_i`=0.
- R12: Opcodes 12..15 write no lane, so every lane takes its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_i | input | 4 | Move opcode (see requirements) |
| arg_i | input | 8 | Quad selectors, or shift/rotate amount in bits 3:0 |
| row_en_i | input | 4 | Per-row write enable |
| bank_en_i | input | 4 | Per-bank write enable |
| bound_zero_i | input | 1 | Invalid source returns zero when 1, keeps old value when 0 |
| exec_i | input | 64 | Per-lane active mask, consulted at the source lane |
| lane_data_i | input | 2048 | Source operands, lane i at bits 32i+31:32i |
| old_data_i | input | 2048 | Old destination values, same packing |
| lane_data_o | output | 2048 | Registered result, same packing |
| out_valid_o | output | 1 | Result updated this cycle |

## Verification
The bench targets the row edges of the shifts. A design that let an out-of-row source through would leak a neighbouring row's data into lanes 0 or 15, where zero or the old value is expected. Broadcasts are checked on both their target and non-target rows: writing row 0 or rows 0..1 would overwrite old values. Masks and exec are mixed so that a disabled lane with an invalid source shows whether enable wins over the bound-zero rule. Wave shifts and rotates are compared at lanes 0 and 63, where shift and rotate must diverge.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [3:0] {
    OP_QPERM      = 4'd0,
    OP_ROW_MIRROR = 4'd1,
    OP_HALF_MIRROR= 4'd2,
    OP_ROW_SHL    = 4'd3,
    OP_ROW_SHR    = 4'd4,
    OP_ROW_ROR    = 4'd5,
    OP_WAVE_SHL   = 4'd6,
    OP_WAVE_SHR   = 4'd7,
    OP_WAVE_ROL   = 4'd8,
    OP_WAVE_ROR   = 4'd9,
    OP_BCAST_ROW  = 4'd10,
    OP_BCAST_31   = 4'd11
  } lm_op_e;
endpackage

// File: rtl/lm_src_map.sv
module lm_src_map
  import lm_pkg::*;
#(
  parameter int ROWS       = 4,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  parameter int LANE_ID    = 0,
  localparam int LANES     = ROWS * ROW_LANES,
  localparam int IDX_W     = $clog2(LANES),
  localparam int QSEL_W    = $clog2(BANK_LANES),
  localparam int ARG_W     = BANK_LANES * QSEL_W
) (
  input  lm_op_e           op,
  input  logic [ARG_W-1:0] arg,
  output logic [IDX_W-1:0] src,
  output logic             in_range,
  output logic             targeted
);
  localparam int ROW      = LANE_ID / ROW_LANES;
  localparam int POS      = LANE_ID % ROW_LANES;
  localparam int ROW_BASE = ROW * ROW_LANES;
  localparam int QPOS     = LANE_ID % BANK_LANES;
  localparam int QBASE    = LANE_ID - QPOS;
  localparam int HALF     = ROW_LANES / 2;
  localparam int AMT_W    = $clog2(ROW_LANES);

  int   s;
  int   amt;

  always_comb begin
    amt      = int'(arg[AMT_W-1:0]);
    s        = LANE_ID;
    in_range = 1'b1;
    targeted = 1'b1;
    unique case (op)
      OP_QPERM:       s = QBASE + int'(arg[QPOS*QSEL_W +: QSEL_W]);
      OP_ROW_MIRROR:  s = ROW_BASE + (ROW_LANES - 1 - POS);
      OP_HALF_MIRROR: s = ROW_BASE + (POS / HALF) * HALF + (HALF - 1 - (POS % HALF));
      OP_ROW_SHL: begin
        in_range = (POS + amt) < ROW_LANES;
        s        = in_range ? LANE_ID + amt : LANE_ID;
      end
      OP_ROW_SHR: begin
        in_range = POS >= amt;
        s        = in_range ? LANE_ID - amt : LANE_ID;
      end
      OP_ROW_ROR:     s = ROW_BASE + ((POS - amt + ROW_LANES) % ROW_LANES);
      OP_WAVE_SHL: begin
        in_range = (LANE_ID != LANES - 1);
        s        = in_range ? LANE_ID + 1 : LANE_ID;
      end
      OP_WAVE_SHR: begin
        in_range = (LANE_ID != 0);
        s        = in_range ? LANE_ID - 1 : LANE_ID;
      end
      OP_WAVE_ROL:    s = (LANE_ID + 1) % LANES;
      OP_WAVE_ROR:    s = (LANE_ID + LANES - 1) % LANES;
      OP_BCAST_ROW: begin
        targeted = (ROW >= 1);
        s        = (ROW >= 1) ? ROW_BASE - 1 : LANE_ID;
      end
      OP_BCAST_31: begin
        targeted = (ROW >= 2);
        s        = 2 * ROW_LANES - 1;
      end
      default:        targeted = 1'b0;
    endcase
    src = IDX_W'(s);
  end
endmodule

// File: rtl/lm_lane_pick.sv
module lm_lane_pick #(
  parameter int ROWS       = 4,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  parameter int W          = 32,
  parameter int LANE_ID    = 0,
  localparam int LANES     = ROWS * ROW_LANES,
  localparam int BANKS     = ROW_LANES / BANK_LANES,
  localparam int IDX_W     = $clog2(LANES)
) (
  input  logic [LANES*W-1:0] data_all,
  input  logic [LANES-1:0]   exec_all,
  input  logic [W-1:0]       old_val,
  input  logic [IDX_W-1:0]   src,
  input  logic               in_range,
  input  logic               targeted,
  input  logic [ROWS-1:0]    row_en,
  input  logic [BANKS-1:0]   bank_en,
  input  logic               bound_zero,
  output logic [W-1:0]       nxt
);
  localparam int ROW  = LANE_ID / ROW_LANES;
  localparam int BANK = (LANE_ID % ROW_LANES) / BANK_LANES;

  logic         wr_en;
  logic         src_ok;
  logic [W-1:0] picked;

  always_comb begin
    wr_en  = targeted & row_en[ROW] & bank_en[BANK];
    src_ok = in_range & exec_all[src];
    picked = data_all[src*W +: W];
    if (!wr_en)          nxt = old_val;
    else if (src_ok)     nxt = picked;
    else if (bound_zero) nxt = '0;
    else                 nxt = old_val;
  end
endmodule

// File: rtl/lm_lane_mover.sv
module lm_lane_mover
  import lm_pkg::*;
#(
  parameter int W          = 32,
  parameter int ROWS       = 4,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  localparam int LANES     = ROWS * ROW_LANES,
  localparam int BANKS     = ROW_LANES / BANK_LANES,
  localparam int IDX_W     = $clog2(LANES),
  localparam int ARG_W     = BANK_LANES * $clog2(BANK_LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [3:0]         op_i,
  input  logic [ARG_W-1:0]   arg_i,
  input  logic [ROWS-1:0]    row_en_i,
  input  logic [BANKS-1:0]   bank_en_i,
  input  logic               bound_zero_i,
  input  logic [LANES-1:0]   exec_i,
  input  logic [LANES*W-1:0] lane_data_i,
  input  logic [LANES*W-1:0] old_data_i,
  output logic [LANES*W-1:0] lane_data_o,
  output logic               out_valid_o
);
  lm_op_e             op_e;
  logic [LANES*W-1:0] data_d;
  logic [LANES*W-1:0] data_q;
  logic               valid_q;

  assign op_e = lm_op_e'(op_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] src;
    logic             in_range;
    logic             targeted;

    lm_src_map #(
      .ROWS(ROWS), .ROW_LANES(ROW_LANES), .BANK_LANES(BANK_LANES), .LANE_ID(g)
    ) u_map (
      .op(op_e), .arg(arg_i), .src(src), .in_range(in_range), .targeted(targeted)
    );

    lm_lane_pick #(
      .ROWS(ROWS), .ROW_LANES(ROW_LANES), .BANK_LANES(BANK_LANES), .W(W), .LANE_ID(g)
    ) u_pick (
      .data_all(lane_data_i), .exec_all(exec_i), .old_val(old_data_i[g*W +: W]),
      .src(src), .in_range(in_range), .targeted(targeted),
      .row_en(row_en_i), .bank_en(bank_en_i), .bound_zero(bound_zero_i),
      .nxt(data_d[g*W +: W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) data_q <= data_d;
    end
  end

  assign lane_data_o = data_q;
  assign out_valid_o = valid_q;
endmodule

// File: rtl/lm_lane_mover_chk.sv
module lm_lane_mover_chk #(
  parameter int LANES = 64,
  parameter int W     = 32,
  parameter int ROWS  = 4,
  parameter int BANKS = 4,
  parameter int ARG_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [3:0]         op_i,
  input logic [ARG_W-1:0]   arg_i,
  input logic [ROWS-1:0]    row_en_i,
  input logic [BANKS-1:0]   bank_en_i,
  input logic               bound_zero_i,
  input logic [LANES-1:0]   exec_i,
  input logic [LANES*W-1:0] lane_data_i,
  input logic [LANES*W-1:0] old_data_i,
  input logic [LANES*W-1:0] lane_data_o,
  input logic               out_valid_o
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid_o);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lane_data_o));

  assert_reserved_keeps_old_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i >= 4'd12) |=> lane_data_o == $past(old_data_i));

  assert_rows_off_keep_old_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && row_en_i == '0) |=> lane_data_o == $past(old_data_i));

  assert_bound_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bound_zero_i && exec_i == '0 && op_i <= 4'd9 &&
     &row_en_i && &bank_en_i) |=> lane_data_o == '0);

  assert_wave_rol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == 4'd8 && &exec_i && &row_en_i && &bank_en_i)
    |=> lane_data_o == {$past(lane_data_i[W-1:0]), $past(lane_data_i[LANES*W-1:W])});
endmodule

bind lm_lane_mover lm_lane_mover_chk #(
  .LANES(LANES), .W(W), .ROWS(ROWS), .BANKS(BANKS), .ARG_W(ARG_W)
) u_chk (.*);

// File: tb/lm_lane_mover_tb.sv
`timescale 1ns/1ps
module lm_lane_mover_tb;
  localparam int W = 32;
  localparam int L = 64;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [3:0]     op_i;
  logic [7:0]     arg_i;
  logic [3:0]     row_en_i, bank_en_i;
  logic           bound_zero_i;
  logic [L-1:0]   exec_i;
  logic [L*W-1:0] lane_data_i, old_data_i, lane_data_o;
  logic           out_valid_o;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] din [L];
  logic [W-1:0] old [L];
  logic [W-1:0] expd[L];
  bit           exp_valid;

  always #2.5 clk = ~clk;

  lm_lane_mover u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i), .arg_i(arg_i),
    .row_en_i(row_en_i), .bank_en_i(bank_en_i), .bound_zero_i(bound_zero_i),
    .exec_i(exec_i), .lane_data_i(lane_data_i), .old_data_i(old_data_i),
    .lane_data_o(lane_data_o), .out_valid_o(out_valid_o)
  );

  function automatic void model();
    for (int l = 0; l < L; l++) begin
      int r = l / 16, k = l % 16, b = (l % 16) / 4, amt = int'(arg_i[3:0]);
      int src = l;
      bit ok = 1, tgt = 1;
      case (op_i)
        4'd0:  src = l - (l % 4) + ((int'(arg_i) >> (2 * (l % 4))) & 3);
        4'd1:  src = r * 16 + 15 - k;
        4'd2:  src = r * 16 + ((k < 8) ? 7 - k : 23 - k);
        4'd3:  if (k + amt > 15) ok = 0; else src = l + amt;
        4'd4:  if (k < amt) ok = 0; else src = l - amt;
        4'd5:  src = r * 16 + (k - amt + 16) % 16;
        4'd6:  if (l == 63) ok = 0; else src = l + 1;
        4'd7:  if (l == 0) ok = 0; else src = l - 1;
        4'd8:  src = (l + 1) % 64;
        4'd9:  src = (l + 63) % 64;
        4'd10: if (r == 0) tgt = 0; else src = r * 16 - 1;
        4'd11: if (r < 2) tgt = 0; else src = 31;
        default: tgt = 0;
      endcase
      if (ok && !exec_i[src]) ok = 0;
      if (!tgt || !row_en_i[r] || !bank_en_i[b]) expd[l] = old[l];
      else if (ok) expd[l] = din[src];
      else expd[l] = bound_zero_i ? '0 : old[l];
    end
  endfunction

  task automatic compare(input string tag);
    int bad = -1;
    tests++;
    if (out_valid_o !== exp_valid) begin
      fails++;
      $display("FAIL R2 (%s) out_valid got %0b exp %0b", tag, out_valid_o, exp_valid);
    end
    tests++;
    for (int l = 0; l < L; l++)
      if (bad < 0 && lane_data_o[l*W +: W] !== expd[l]) bad = l;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s lane %0d got %h exp %h", tag, bad, lane_data_o[bad*W +: W], expd[bad]);
    end
  endtask

  task automatic step(input bit v, input logic [3:0] op, input logic [7:0] arg,
                      input logic [3:0] rm, input logic [3:0] bm, input bit bz,
                      input logic [L-1:0] ex, input string tag);
    in_valid = v; op_i = op; arg_i = arg; row_en_i = rm; bank_en_i = bm;
    bound_zero_i = bz; exec_i = ex;
    for (int l = 0; l < L; l++) begin
      din[l] = $urandom; old[l] = $urandom;
      lane_data_i[l*W +: W] = din[l];
      old_data_i[l*W +: W]  = old[l];
    end
    if (v) model();
    exp_valid = v;
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [L-1:0] ALL = '1;

  initial begin
    rst_n = 0; in_valid = 0; op_i = 0; arg_i = 0; row_en_i = 4'hF; bank_en_i = 4'hF;
    bound_zero_i = 0; exec_i = '0; lane_data_i = '0; old_data_i = '0;
    exp_valid = 0;
    for (int l = 0; l < L; l++) expd[l] = '0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after release");

    step(1, 4'd0, 8'b00011011, 4'hF, 4'hF, 1, ALL, "R3 quad reverse");
    step(1, 4'd0, 8'hE4, 4'hF, 4'hF, 1, ALL, "R3 quad identity");
    step(1, 4'd0, 8'h55, 4'hF, 4'hF, 1, ALL, "R3 quad splat1");
    step(1, 4'd1, 8'h00, 4'hF, 4'hF, 1, ALL, "R4 row mirror");
    step(1, 4'd2, 8'h00, 4'hF, 4'hF, 1, ALL, "R4 half mirror");
    step(1, 4'd3, 8'h03, 4'hF, 4'hF, 1, ALL, "R5 shl3 zero");
    step(1, 4'd4, 8'h05, 4'hF, 4'hF, 0, ALL, "R5 R11 shr5 keep");
    step(1, 4'd3, 8'h0F, 4'hF, 4'hF, 1, ALL, "R5 shl15");
    step(1, 4'd4, 8'h00, 4'hF, 4'hF, 1, ALL, "R5 shr0");
    step(1, 4'd5, 8'h07, 4'hF, 4'hF, 1, ALL, "R6 ror7");
    step(1, 4'd5, 8'h0F, 4'hF, 4'hF, 1, ALL, "R6 ror15");
    step(1, 4'd6, 8'h00, 4'hF, 4'hF, 1, ALL, "R7 wave shl");
    step(1, 4'd7, 8'h00, 4'hF, 4'hF, 1, ALL, "R7 wave shr");
    step(1, 4'd8, 8'h00, 4'hF, 4'hF, 1, ALL, "R7 wave rol");
    step(1, 4'd9, 8'h00, 4'hF, 4'hF, 1, ALL, "R7 wave ror");
    step(1, 4'd10, 8'h00, 4'hF, 4'hF, 1, ALL, "R8 bcast row");
    step(1, 4'd11, 8'h00, 4'hF, 4'hF, 1, ALL, "R8 bcast 31");
    step(1, 4'd1, 8'h00, 4'b1010, 4'b0110, 1, ALL, "R9 masks");
    step(1, 4'd6, 8'h00, 4'b0111, 4'b1101, 1, 64'h0F0F_0000_FFFF_1234, "R9 masks exec");
    step(1, 4'd1, 8'h00, 4'hF, 4'hF, 1, 64'hA5A5_F00F_0FF0_5A5A, "R10 exec zero");
    step(1, 4'd8, 8'h00, 4'hF, 4'hF, 1, '0, "R10 all inactive");
    step(1, 4'd1, 8'h00, 4'hF, 4'hF, 0, 64'hA5A5_F00F_0FF0_5A5A, "R11 exec keep");
    step(1, 4'd12, 8'h00, 4'hF, 4'hF, 1, ALL, "R12 op12");
    step(1, 4'd15, 8'h00, 4'hF, 4'hF, 0, ALL, "R12 op15");
    step(0, 4'd1, 8'h00, 4'hF, 4'hF, 1, ALL, "R2 idle hold");
    step(0, 4'd8, 8'h00, 4'h0, 4'h0, 0, '0, "R2 idle hold 2");
    for (int n = 0; n < 300; n++)
      step(($urandom % 5) != 0, 4'($urandom), 8'($urandom), 4'($urandom | 32'h9),
           4'($urandom | 32'h6), 1'($urandom), {$urandom, $urandom} | {$urandom, $urandom},
           "RND R3 R9 R10 R11");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule